// File: doc/BRIEF.md
# Multi-Line Tagged Receive Silo

This block collects received characters from several serial receivers into a single shared FIFO. Each stored entry carries the character, the number of the line it arrived on, and the parity and framing error flags that came with it. When characters are lost because the FIFO was full, the loss is recorded in the next entry that does get stored, so software finds the overrun in the data stream at the point where the gap occurred.

Each line presents a one-cycle "character ready" strobe with its data and error bits. Every line has a one-entry holding slot. The slots drain into the FIFO at one entry per cycle, and the lowest-numbered waiting line goes first. Software reads the silo through a register-style port. A read strobe returns the oldest entry as a 16-bit word and removes that entry in the same access. A receive-done status bit and an interrupt request, gated by an enable input, report that data is waiting.

Top module: `rx_silo`

## Requirements
- R1: The silo stores up to 64 entries. With 64 entries stored and none read, further characters are not stored.
- R2: A read word holds the character in bits 7:0, the source line number in bits 9:8, zero in bits 11:10, the parity error flag in bit 12, the framing/break flag in bit 13, the overrun flag in bit 14 and the valid flag in bit 15.
- R3: A read strobe sampled at a clock edge loads `rd_data` at that edge with the oldest entry, valid bit set, and removes that entry. When the silo is empty it loads all zeros. `rd_data` keeps the word of the latest read until the next read.
- R4: `rx_done` is 1 exactly while at least one entry is stored. It changes at the same clock edge as the stored count.
- R5: `rx_irq` is 1 only when `rx_done` is 1 and `rx_irq_en` was 1 at the previous clock edge.
- R6: A strobe on a line whose bit in `line_en` is 0 is ignored and never produces an entry.
- R7: A cycle with `master_clr` high empties the silo, discards characters waiting in the holding slots, clears the pending overrun and zeroes `rd_data`.
- R8: A character that reaches a full silo is dropped. The next entry that is stored has bit 14 set. Entries stored after that have bit 14 clear unless another drop occurs.
- R9: Characters strobed on several lines in the same cycle are stored in ascending line order, one per cycle. A character strobed at edge k is stored at edge k+1 when no lower-numbered line is waiting.
- R10: Entries are read back in the order in which they were stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_clr | input | 1 | Synchronous clear of the silo and the holding slots |
| line_en | input | NUM_LINES | Receiver enable, one bit per line |
| rx_stb | input | NUM_LINES | Character-ready strobe, one bit per line |
| rx_char | input | NUM_LINES*8 | Received characters; line i uses bits 8i+7:8i |
| rx_perr | input | NUM_LINES | Parity error flag, one per line |
| rx_ferr | input | NUM_LINES | Framing error / break flag, one per line |
| rd_strobe | input | 1 | Read access: returns the head entry and removes it |
| rx_irq_en | input | 1 | Receive interrupt enable |
| rd_data | output | 16 | Word returned by the latest read access |
| rx_done | output | 1 | At least one entry is stored |
| rx_irq | output | 1 | Gated receive interrupt request |

## Verification
A single character on one line, with error flags set, checks the field layout and the one-cycle path from the holding slot into the FIFO. Strobes on three lines in the same cycle, and on an enabled and a disabled line together, separate a correct ascending drain from a dropped or reordered entry and show that a disabled line leaves no trace. A full fill of the silo followed by extra strobes, then a single read and another write, shows where the overrun mark lands and that it does not leak into neighbouring entries. A master clear issued while the holding slots are still draining shows that no stale character survives.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;

  localparam int CHAR_W = 8;
  localparam int TAG_W  = 2;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic              ovr;
    logic              ferr;
    logic              perr;
    logic [TAG_W-1:0]  line;
    logic [CHAR_W-1:0] ch;
  } ent_t;

  localparam int ENT_W = $bits(ent_t);

  function automatic logic [WORD_W-1:0] word_of(input ent_t e);
    return {1'b1, e.ovr, e.ferr, e.perr, 2'b00, e.line, e.ch};
  endfunction

endpackage

// File: rtl/rx_line_stage.sv
module rx_line_stage #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic              stb,
  input  logic [CHAR_W-1:0] ch,
  input  logic              perr,
  input  logic              ferr,
  input  logic              take,
  output logic              vld,
  output logic [CHAR_W-1:0] q_ch,
  output logic              q_perr,
  output logic              q_ferr
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      vld <= 1'b0;
    end else if (stb && en) begin
      vld <= 1'b1;
    end else if (take) begin
      vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_ch   <= '0;
      q_perr <= 1'b0;
      q_ferr <= 1'b0;
    end else if (stb && en) begin
      q_ch   <= ch;
      q_perr <= perr;
      q_ferr <= ferr;
    end
  end

endmodule

// File: rtl/rx_pick.sv
module rx_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any = |req;
    gnt = '0;
    if (any) gnt[idx] = 1'b1;
  end

endmodule

// File: rtl/rx_silo_mem.sv
module rx_silo_mem
  import rx_silo_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_req,
  input  ent_t              wr_ent,
  input  logic              rd_req,
  output logic [WORD_W-1:0] rd_word,
  output logic              nonempty,
  output logic              nonempty_nxt
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  ent_t            mem [DEPTH];
  ent_t            rd_q;
  ent_t            wr_e;
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [CW-1:0]   cnt, cnt_nxt;
  logic            ovr_pend, rd_hit, full, empty, do_wr, do_rd;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign do_wr = wr_req && !full && !clr;
  assign do_rd = rd_req && !empty && !clr;

  always_comb begin
    wr_e     = wr_ent;
    wr_e.ovr = ovr_pend;
  end

  assign cnt_nxt      = cnt + CW'(do_wr) - CW'(do_rd);
  assign nonempty_nxt = !clr && (cnt_nxt != '0);

  // storage: no reset, single write and single registered read port
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_e;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rd_q <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      ovr_pend <= 1'b0;
      rd_hit   <= 1'b0;
      nonempty <= 1'b0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      cnt      <= cnt_nxt;
      nonempty <= nonempty_nxt;
      if (wr_req && full) ovr_pend <= 1'b1;
      else if (do_wr)     ovr_pend <= 1'b0;
      if (rd_req) rd_hit <= !empty;
    end
  end

  assign rd_word = rd_hit ? word_of(rd_q) : '0;

endmodule

// File: rtl/rx_silo.sv
module rx_silo
  import rx_silo_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int DEPTH     = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        master_clr,
  input  logic [NUM_LINES-1:0]        line_en,
  input  logic [NUM_LINES-1:0]        rx_stb,
  input  logic [NUM_LINES*CHAR_W-1:0] rx_char,
  input  logic [NUM_LINES-1:0]        rx_perr,
  input  logic [NUM_LINES-1:0]        rx_ferr,
  input  logic                        rd_strobe,
  input  logic                        rx_irq_en,
  output logic [WORD_W-1:0]           rd_data,
  output logic                        rx_done,
  output logic                        rx_irq
);

  localparam int IW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [NUM_LINES-1:0] slot_vld, slot_perr, slot_ferr, gnt;
  logic [CHAR_W-1:0]    slot_ch [NUM_LINES];
  logic [IW-1:0]        sel;
  logic                 any;
  logic                 nonempty_nxt;
  ent_t                 wr_ent;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    rx_line_stage #(.CHAR_W(CHAR_W)) u_stage (
      .clk    (clk),
      .rst    (rst),
      .clr    (master_clr),
      .en     (line_en[i]),
      .stb    (rx_stb[i]),
      .ch     (rx_char[i*CHAR_W +: CHAR_W]),
      .perr   (rx_perr[i]),
      .ferr   (rx_ferr[i]),
      .take   (gnt[i]),
      .vld    (slot_vld[i]),
      .q_ch   (slot_ch[i]),
      .q_perr (slot_perr[i]),
      .q_ferr (slot_ferr[i])
    );
  end

  rx_pick #(.N(NUM_LINES)) u_pick (
    .req (slot_vld),
    .gnt (gnt),
    .idx (sel),
    .any (any)
  );

  always_comb begin
    wr_ent      = '0;
    wr_ent.ch   = slot_ch[sel];
    wr_ent.line = TAG_W'(sel);
    wr_ent.perr = slot_perr[sel];
    wr_ent.ferr = slot_ferr[sel];
  end

  rx_silo_mem #(.DEPTH(DEPTH)) u_mem (
    .clk          (clk),
    .rst          (rst),
    .clr          (master_clr),
    .wr_req       (any),
    .wr_ent       (wr_ent),
    .rd_req       (rd_strobe),
    .rd_word      (rd_data),
    .nonempty     (rx_done),
    .nonempty_nxt (nonempty_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) rx_irq <= 1'b0;
    else     rx_irq <= nonempty_nxt && rx_irq_en;
  end

endmodule

// File: rtl/rx_silo_chk.sv
module rx_silo_chk (
  input logic        clk,
  input logic        rst,
  input logic        master_clr,
  input logic        rd_strobe,
  input logic        rx_irq_en,
  input logic [15:0] rd_data,
  input logic        rx_done,
  input logic        rx_irq
);

  assert_zero_gap_R2: assert property (@(posedge clk) disable iff (rst)
    rd_data[11:10] == 2'b00);

  assert_empty_read_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !rx_done && !master_clr) |=> (rd_data == 16'h0000));

  assert_head_read_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && rx_done && !master_clr) |=> rd_data[15]);

  assert_irq_needs_data_R5: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> rx_done);

  assert_irq_gated_R5: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> $past(rx_irq_en));

  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (rst)
    master_clr |=> (!rx_done && rd_data == 16'h0000));

endmodule

bind rx_silo rx_silo_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .master_clr (master_clr),
  .rd_strobe  (rd_strobe),
  .rx_irq_en  (rx_irq_en),
  .rd_data    (rd_data),
  .rx_done    (rx_done),
  .rx_irq     (rx_irq)
);

// File: tb/sim_rx_silo.sv
`timescale 1ns/1ps
module sim_rx_silo;

  localparam int NL = 4;
  localparam int DP = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          master_clr = 1'b0;
  logic [NL-1:0] line_en = '1;
  logic [NL-1:0] rx_stb = '0;
  logic [NL*8-1:0] rx_char = '0;
  logic [NL-1:0] rx_perr = '0;
  logic [NL-1:0] rx_ferr = '0;
  logic          rd_strobe = 1'b0;
  logic          rx_irq_en = 1'b0;
  logic [15:0]   rd_data;
  logic          rx_done;
  logic          rx_irq;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  rx_silo #(.NUM_LINES(NL), .DEPTH(DP)) u0 (
    .clk(clk), .rst(rst), .master_clr(master_clr), .line_en(line_en),
    .rx_stb(rx_stb), .rx_char(rx_char), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
    .rd_strobe(rd_strobe), .rx_irq_en(rx_irq_en),
    .rd_data(rd_data), .rx_done(rx_done), .rx_irq(rx_irq)
  );

  function automatic logic [15:0] ew(input int ln, input logic [7:0] c,
                                     input bit p, input bit f, input bit o);
    return {1'b1, o, f, p, 2'b00, 2'(ln), c};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one-cycle strobe on the lines in mask, all carrying the same char offset by line
  task automatic send(input logic [NL-1:0] mask, input logic [7:0] c,
                      input bit p, input bit f);
    @(negedge clk);
    rx_stb = mask;
    for (int i = 0; i < NL; i++) rx_char[i*8 +: 8] = c + 8'(i);
    rx_perr = p ? mask : '0;
    rx_ferr = f ? mask : '0;
    @(posedge clk);
    @(negedge clk);
    rx_stb = '0; rx_perr = '0; rx_ferr = '0;
  endtask

  task automatic rd(output logic [15:0] w);
    @(negedge clk);
    rd_strobe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_strobe = 1'b0;
    w = rd_data;
  endtask

  task automatic t_reset;
    chk("R4 reset rx_done", 16'(rx_done), 16'h0);
    chk("R5 reset rx_irq", 16'(rx_irq), 16'h0);
    chk("R3 reset rd_data", rd_data, 16'h0);
  endtask

  task automatic t_single;
    logic [15:0] w;
    // strobe at edge k, stored at edge k+1
    @(negedge clk);
    rx_stb = 4'b0100; rx_char[16 +: 8] = 8'h5A; rx_perr = 4'b0100; rx_ferr = 4'b0100;
    @(posedge clk);
    @(negedge clk);
    rx_stb = '0; rx_perr = '0; rx_ferr = '0;
    chk("R9 not yet stored after capture edge", 16'(rx_done), 16'h0);
    tick(1);
    chk("R4 done after store edge", 16'(rx_done), 16'h1);
    rd(w);
    chk("R2 layout line2 perr ferr", w, ew(2, 8'h5A, 1, 1, 0));
    chk("R4 done clears after pop", 16'(rx_done), 16'h0);
    tick(2);
    chk("R3 rd_data held", rd_data, ew(2, 8'h5A, 1, 1, 0));
    rd(w);
    chk("R3 empty read zero", w, 16'h0);
  endtask

  task automatic t_simul;
    logic [15:0] w;
    send(4'b1101, 8'h10, 0, 0);
    tick(4);
    rd(w); chk("R9 first is line0", w, ew(0, 8'h10, 0, 0, 0));
    rd(w); chk("R9 second is line2", w, ew(2, 8'h12, 0, 0, 0));
    rd(w); chk("R9 third is line3", w, ew(3, 8'h13, 0, 0, 0));
    rd(w); chk("R3 empty after three", w, 16'h0);
  endtask

  task automatic t_disabled;
    logic [15:0] w;
    line_en = 4'b1011;
    send(4'b0100, 8'h40, 0, 0);
    tick(3);
    chk("R6 disabled line no done", 16'(rx_done), 16'h0);
    send(4'b0110, 8'h40, 1, 0);
    tick(3);
    rd(w); chk("R6 only enabled line1 stored", w, ew(1, 8'h41, 1, 0, 0));
    rd(w); chk("R6 nothing from line2", w, 16'h0);
    line_en = '1;
  endtask

  task automatic t_irq;
    logic [15:0] w;
    rx_irq_en = 1'b0;
    send(4'b0001, 8'h77, 0, 0);
    tick(3);
    chk("R5 irq off when disabled", 16'(rx_irq), 16'h0);
    rx_irq_en = 1'b1;
    tick(1);
    chk("R5 irq on when enabled", 16'(rx_irq), 16'h1);
    rd(w);
    chk("R5 irq drops when empty", 16'(rx_irq), 16'h0);
    chk("R10 irq entry", w, ew(0, 8'h77, 0, 0, 0));
    rx_irq_en = 1'b0;
  endtask

  task automatic t_overrun;
    logic [15:0] w;
    bit ok;
    for (int i = 0; i < DP; i++) send(4'b0001, 8'(i), 0, 0);
    send(4'b0001, 8'hA0, 0, 0);
    send(4'b0001, 8'hA1, 0, 0);
    tick(3);
    rd(w); chk("R1 head after fill", w, ew(0, 8'h00, 0, 0, 0));
    send(4'b0001, 8'hB0, 0, 0);
    tick(3);
    ok = 1;
    for (int i = 1; i < DP; i++) begin
      rd(w);
      if (w !== ew(0, 8'(i), 0, 0, 0)) begin
        ok = 0;
        chk("R10 fill order", w, ew(0, 8'(i), 0, 0, 0));
      end
    end
    chk("R10 all 63 in order", 16'(ok), 16'h1);
    rd(w); chk("R8 overrun marked in next stored", w, ew(0, 8'hB0, 0, 0, 1));
    rd(w); chk("R1 dropped chars absent", w, 16'h0);
    send(4'b0001, 8'hC0, 0, 0);
    tick(3);
    rd(w); chk("R8 overrun mark not repeated", w, ew(0, 8'hC0, 0, 0, 0));
  endtask

  task automatic t_clear;
    logic [15:0] w;
    send(4'b0011, 8'h20, 0, 0);
    tick(3);
    rd(w); chk("R10 pre-clear read", w, ew(0, 8'h20, 0, 0, 0));
    send(4'b1111, 8'h60, 0, 0);
    master_clr = 1'b1;
    tick(1);
    master_clr = 1'b0;
    chk("R7 done cleared", 16'(rx_done), 16'h0);
    chk("R7 rd_data cleared", rd_data, 16'h0);
    tick(5);
    chk("R7 held slots discarded", 16'(rx_done), 16'h0);
    rd(w); chk("R7 empty after clear", w, 16'h0);
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_single();
    t_simul();
    t_disabled();
    t_irq();
    t_overrun();
    t_clear();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule